// File: doc/BRIEF.md
# Sampled Audio Playback Voice

This block is a single voice of a sample-playback sound engine. It fetches 16-bit words from a sample memory through a request/acknowledge read port. Each word holds two signed 8-bit samples. A programmable period sets how often the next sample is emitted, and every emitted sample is multiplied by a volume before it leaves the block.

Software writes four values through a small write port: the start word address, the block length in words, the period in clock cycles, and the volume. The start address and length sit in latches, and the working address and length counters copy them only when a block boundary is reached. New values can therefore be queued while the current block plays. If nothing new is written, the block simply loops. A one-cycle interrupt marks each copy into the working counters, which tells software that the latches may be written again.

One fetched word waits in a holding latch while the previous word plays. Memory latency is therefore hidden behind the playback of two samples.

Top module: `sample_voice`

## Requirements
- R1: After reset, `smp_out` is 0 and `mem_req`, `blk_irq` and `smp_tick` are low.
- R2: While `play_en` is high, `smp_tick` pulses once every P cycles, where P is the effective period. The first pulse follows the P-th clock edge with `play_en` high. `smp_out` changes only together with `smp_tick`.
- R3: Samples come out in ascending word order starting at the latched start address, with bits 15:8 of each word before bits 7:0.
- R4: Each word is read once. `mem_req` stays high with `mem_addr` unchanged until `mem_ack`, and drops in the cycle after the acknowledge. A new read is issued only once the holding latch has been emptied.
- R5: After the last word of a block has been read, the working address and the remaining count reload from the start and length latches, so playback loops or moves on to a queued block.
- R6: `blk_irq` is a one-cycle pulse. It appears in the cycle after playback is enabled and in the cycle after the acknowledge of each block's last word.
- R7: Writes to start (select 0) and length (select 1) reach only the latches and take effect at the next reload. A write on the same clock edge as a reload leaves that reload with the old value.
- R8: `smp_out` equals the signed sample times min(volume, 64). Volume is written with select 3 and taken from bits 6:0. The output never leaves -8192..8128.
- R9: The period is written with select 2. A value below 4 is treated as 4, so consecutive `smp_tick` pulses are at least 4 cycles apart.
- R10: A length of 0 is treated as a length of 1.
- R11: While `play_en` is low, no new read is issued and no sample is emitted, and held data is dropped. Raising `play_en` again restarts playback from the latched start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | Playback enable |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_sel | input | 2 | Parameter select: 0 start, 1 length, 2 period, 3 volume |
| cfg_data | input | 16 | Parameter write value |
| mem_req | output | 1 | Sample word read request |
| mem_addr | output | 16 | Word address of the read |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Sample word, two signed bytes |
| smp_out | output | 15 | Scaled signed sample |
| smp_tick | output | 1 | Pulse when a new sample is emitted |
| blk_irq | output | 1 | Pulse when the working counters reload |

## Verification
The two functions that can fall in the same cycle are a software write to the start latch and the reload that the acknowledge of a block's last word triggers. The bench provokes this by driving the start write on exactly the clock edge on which it acknowledges that final word. It then judges the outcome from the fetch addresses it sees: the next block must repeat the old start, and only the block after that may begin at the new one. Period, length and volume are swept over small sets that include the clamped values, and every sample value and spacing is checked against arithmetic in the bench.

// File: rtl/voice_pkg.sv
package voice_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_LEN   = 2'd1,
    SEL_PER   = 2'd2,
    SEL_VOL   = 2'd3
  } cfg_sel_e;

  localparam int unsigned MIN_PER = 4;
  localparam int unsigned VOL_MAX = 64;
endpackage

// File: rtl/voice_cfg.sv
module voice_cfg
  import voice_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int PW = 16,
  parameter int VW = 7,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] data,
  output logic [AW-1:0] start_o,
  output logic [LW-1:0] len_o,
  output logic [PW-1:0] per_o,
  output logic [VW-1:0] vol_o
);
  logic [AW-1:0] start_q, start_n;
  logic [LW-1:0] len_q, len_n;
  logic [PW-1:0] per_q, per_n;
  logic [VW-1:0] vol_q, vol_n;

  always_comb begin
    start_n = start_q;
    len_n   = len_q;
    per_n   = per_q;
    vol_n   = vol_q;
    if (we) begin
      case (cfg_sel_e'(sel))
        SEL_START: start_n = data[AW-1:0];
        SEL_LEN:   len_n   = data[LW-1:0];
        SEL_PER:   per_n   = data[PW-1:0];
        default:   vol_n   = data[VW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      len_q   <= LW'(1);
      per_q   <= PW'(MIN_PER);
      vol_q   <= '0;
    end else begin
      start_q <= start_n;
      len_q   <= len_n;
      per_q   <= per_n;
      vol_q   <= vol_n;
    end
  end

  // clamped views seen by the working logic
  assign start_o = start_q;
  assign len_o   = (len_q == '0) ? LW'(1) : len_q;
  assign per_o   = (per_q < PW'(MIN_PER)) ? PW'(MIN_PER) : per_q;
  assign vol_o   = (vol_q > VW'(VOL_MAX)) ? VW'(VOL_MAX) : vol_q;
endmodule

// File: rtl/voice_fetch.sv
module voice_fetch #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] start_i,
  input  logic [LW-1:0] len_i,
  input  logic          take_i,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] word_o,
  output logic          full_o,
  output logic          irq_o
);
  logic          run_q, pend_q, pend_n, full_q, full_n, irq_q, irq_n;
  logic [AW-1:0] addr_q, addr_n, raddr_q, raddr_n;
  logic [LW-1:0] left_q, left_n;
  logic [DW-1:0] word_q, word_n;
  logic          load, got, issue;

  assign load  = run & ~run_q;
  assign got   = mem_ack & pend_q & run & run_q;
  assign issue = run & run_q & ~full_q & ~pend_q;

  always_comb begin
    addr_n  = addr_q;
    left_n  = left_q;
    word_n  = word_q;
    full_n  = full_q;
    pend_n  = pend_q;
    raddr_n = raddr_q;
    irq_n   = 1'b0;
    if (load) begin
      addr_n = start_i;
      left_n = len_i;
      irq_n  = 1'b1;
    end
    if (got) begin
      word_n = mem_rdata;
      full_n = 1'b1;
      if (left_q == LW'(1)) begin
        addr_n = start_i;
        left_n = len_i;
        irq_n  = 1'b1;
      end else begin
        addr_n = addr_q + AW'(1);
        left_n = left_q - LW'(1);
      end
    end
    if (mem_ack && pend_q) begin
      pend_n = 1'b0;
    end else if (issue) begin
      pend_n  = 1'b1;
      raddr_n = addr_q;
    end
    if (take_i) full_n = 1'b0;
    if (!run)   full_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      addr_q  <= '0;
      raddr_q <= '0;
      left_q  <= LW'(1);
      word_q  <= '0;
    end else begin
      run_q   <= run;
      pend_q  <= pend_n;
      full_q  <= full_n;
      irq_q   <= irq_n;
      addr_q  <= addr_n;
      raddr_q <= raddr_n;
      left_q  <= left_n;
      word_q  <= word_n;
    end
  end

  assign mem_req  = pend_q;
  assign mem_addr = raddr_q;
  assign word_o   = word_q;
  assign full_o   = full_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/voice_play.sv
module voice_play #(
  parameter int PW = 16,
  parameter int VW = 7,
  parameter int SW = 8,
  localparam int DW = 2 * SW,
  localparam int OW = SW + VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] per_i,
  input  logic [VW-1:0] vol_i,
  input  logic [DW-1:0] word_i,
  input  logic          full_i,
  output logic          take_o,
  output logic [OW-1:0] out_o,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q, cnt_n;
  logic          ph_q, ph_n, tick_q, tick_n;
  logic [SW-1:0] low_q, low_n, pick;
  logic [OW-1:0] out_q, out_n;
  logic signed [OW-1:0] s_ext, v_ext, prod;
  logic          expire, emit;

  assign expire = run & (cnt_q <= PW'(1));
  assign take_o = expire & ~ph_q & full_i;

  always_comb begin
    s_ext = {{VW{pick[SW-1]}}, pick};
    v_ext = {{SW{1'b0}}, vol_i};
    prod  = s_ext * v_ext;
  end

  always_comb begin
    cnt_n = cnt_q;
    ph_n  = ph_q;
    low_n = low_q;
    out_n = out_q;
    emit  = 1'b0;
    pick  = word_i[DW-1:SW];
    if (!run) begin
      cnt_n = per_i;
      ph_n  = 1'b0;
    end else if (expire) begin
      cnt_n = per_i;
    end else begin
      cnt_n = cnt_q - PW'(1);
    end
    if (expire) begin
      if (ph_q) begin
        pick = low_q;
        emit = 1'b1;
        ph_n = 1'b0;
      end else if (full_i) begin
        low_n = word_i[SW-1:0];
        emit  = 1'b1;
        ph_n  = 1'b1;
      end
    end
    if (emit) out_n = prod;
    tick_n = emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= PW'(4);
      ph_q   <= 1'b0;
      low_q  <= '0;
      out_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      ph_q   <= ph_n;
      low_q  <= low_n;
      out_q  <= out_n;
      tick_q <= tick_n;
    end
  end

  assign out_o  = out_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/sample_voice.sv
module sample_voice #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int PW = 16,
  parameter int VW = 7,
  parameter int SW = 8,
  parameter int CW = 16,
  localparam int DW = 2 * SW,
  localparam int OW = SW + VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play_en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [CW-1:0] cfg_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [OW-1:0] smp_out,
  output logic          smp_tick,
  output logic          blk_irq
);
  logic [1:0]    rsync_q;
  logic          irst_n;
  logic [AW-1:0] start_w;
  logic [LW-1:0] len_w;
  logic [PW-1:0] per_w;
  logic [VW-1:0] vol_w;
  logic [DW-1:0] word_w;
  logic          full_w, take_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign irst_n = rsync_q[1];

  voice_cfg #(.AW(AW), .LW(LW), .PW(PW), .VW(VW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(irst_n), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .start_o(start_w), .len_o(len_w), .per_o(per_w), .vol_o(vol_w)
  );

  voice_fetch #(.AW(AW), .LW(LW), .DW(DW)) u_fetch (
    .clk(clk), .rst_n(irst_n), .run(play_en), .start_i(start_w), .len_i(len_w),
    .take_i(take_w), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .word_o(word_w), .full_o(full_w),
    .irq_o(blk_irq)
  );

  voice_play #(.PW(PW), .VW(VW), .SW(SW)) u_play (
    .clk(clk), .rst_n(irst_n), .run(play_en), .per_i(per_w), .vol_i(vol_w),
    .word_i(word_w), .full_i(full_w), .take_o(take_w),
    .out_o(smp_out), .tick_o(smp_tick)
  );
endmodule

// File: rtl/voice_chk.sv
module voice_chk #(
  parameter int AW = 16,
  parameter int OW = 15,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          play_en,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [OW-1:0] smp_out,
  input logic          smp_tick,
  input logic          blk_irq
);
  localparam int HI = (2 ** (SW - 1) - 1) * 64;
  localparam int LO = -(2 ** (SW - 1)) * 64;

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq |=> !blk_irq);

  assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick |=> !smp_tick ##1 !smp_tick ##1 !smp_tick);

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_tick |-> $stable(smp_out));

  assert_out_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'($signed(smp_out)) <= HI) && (int'($signed(smp_out)) >= LO));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!play_en && !mem_req) |=> !mem_req);
endmodule

bind sample_voice voice_chk #(.AW(AW), .OW(OW), .SW(SW)) u_voice_chk (
  .clk(clk), .rst_n(rst_n), .play_en(play_en), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .smp_out(smp_out),
  .smp_tick(smp_tick), .blk_irq(blk_irq)
);

// File: tb/sample_voice_bench.sv
module sample_voice_bench;
  import voice_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, play_en, cfg_we, mem_ack, mem_req, smp_tick, blk_irq;
  logic [1:0]  cfg_sel, sel_m, sel_p;
  logic [15:0] cfg_data, d_m, d_p, mem_addr, mem_rdata;
  logic        we_m, we_p;
  logic [14:0] smp_out;

  assign cfg_we   = we_m | we_p;
  assign cfg_sel  = we_p ? sel_p : sel_m;
  assign cfg_data = we_p ? d_p : d_m;

  sample_voice u_sample_voice (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .smp_out(smp_out), .smp_tick(smp_tick), .blk_irq(blk_irq)
  );

  int total = 0, bad = 0;
  int nxt_base = 0, nxt_len = 1, per_raw = 4, vol_raw = 0;
  int blk_base = 0, blk_len = 1, off = 0, n_ticks = 0, edges = 0;
  bit en_seen = 0, ph = 0, stopping = 1, provoke = 0;
  int provoke_val = 0;
  logic [7:0]  lowb;
  logic [15:0] q[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int eff_len(int l); return (l == 0) ? 1 : l; endfunction
  function automatic int eff_per(int p); return (p < 4) ? 4 : p; endfunction
  function automatic int eff_vol(int v); return (v > 64) ? 64 : v; endfunction
  function automatic logic [15:0] word_at(logic [15:0] a);
    logic [7:0] x;
    x = a[7:0];
    return {x ^ 8'hA5, x + 8'h3C};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // latch model: follows the write port exactly as written (R7)
  always @(posedge clk) begin
    en_seen <= play_en;
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: nxt_base <= int'(cfg_data);
        2'd1: nxt_len  <= int'(cfg_data);
        2'd2: per_raw  <= int'(cfg_data);
        default: vol_raw <= int'(cfg_data[6:0]);
      endcase
    end
  end

  // memory model, fetch address (R4) and reload interrupt (R5, R6) checks
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; we_p = 1'b0; sel_p = '0; d_p = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        int exp_a; bit last, live; int dly;
        exp_a = (blk_base + off) & 16'hFFFF;
        dly = (eff_per(per_raw) >= 6) ? 1 : 0;
        if (!stopping) check(mem_addr == exp_a[15:0], "R4 R5 fetch address", int'(mem_addr), exp_a);
        repeat (dly) @(negedge clk);
        live = !stopping;
        last = (off == blk_len - 1);
        mem_ack = 1'b1;
        mem_rdata = word_at(mem_addr);
        if (live) q.push_back(word_at(mem_addr));
        if (live && provoke && last) begin
          we_p = 1'b1; sel_p = SEL_START; d_p = provoke_val[15:0];
        end
        if (last) begin
          off = 0; blk_base = nxt_base; blk_len = eff_len(nxt_len);
        end else off++;
        @(negedge clk);
        mem_ack = 1'b0;
        if (live) check(blk_irq == last, "R6 irq after block end", int'(blk_irq), int'(last));
        if (we_p) begin we_p = 1'b0; provoke = 0; end
      end
    end
  end

  // sample monitor: spacing (R2, R9), order (R3), scaling (R8)
  initial forever begin
    @(negedge clk);
    if (!en_seen) begin
      edges = 0; ph = 0;
    end else begin
      edges++;
      if (smp_tick) begin
        logic [7:0] b; logic [15:0] w; int exp_v;
        check(edges == eff_per(per_raw), "R2 R9 sample spacing", edges, eff_per(per_raw));
        edges = 0;
        if (!ph) begin
          if (q.size() == 0) begin check(0, "R3 sample without word", 0, 1); b = 8'h00; end
          else begin w = q.pop_front(); b = w[15:8]; lowb = w[7:0]; end
          ph = 1;
        end else begin
          b = lowb; ph = 0;
        end
        exp_v = int'($signed(b)) * eff_vol(vol_raw);
        check(int'($signed(smp_out)) == exp_v, "R3 R8 sample value", int'($signed(smp_out)), exp_v);
        n_ticks++;
      end
    end
  end

  task automatic cfg_write(logic [1:0] s, int v);
    @(negedge clk);
    we_m = 1'b1; sel_m = s; d_m = v[15:0];
    @(negedge clk);
    we_m = 1'b0;
  endtask

  task automatic start_play();
    @(negedge clk);
    blk_base = nxt_base; blk_len = eff_len(nxt_len); off = 0;
    q.delete(); stopping = 0;
    play_en = 1'b1;
    @(negedge clk);
    check(blk_irq == 1'b1, "R6 irq on enable", int'(blk_irq), 1);
  endtask

  task automatic stop_play();
    stopping = 1;
    @(negedge clk);
    play_en = 1'b0;
    repeat (3) @(negedge clk);
    check(smp_tick == 1'b0 && mem_req == 1'b0, "R11 quiet when disabled", int'(smp_tick | mem_req), 0);
    repeat (5) @(negedge clk);
    q.delete();
  endtask

  task automatic wait_ticks(int n);
    int t0;
    t0 = n_ticks;
    while (n_ticks < t0 + n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R2 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pers[4] = '{0, 2, 4, 7};
    int vols[5] = '{0, 1, 33, 64, 100};
    int lens[3] = '{0, 1, 3};
    rst_n = 1'b0; play_en = 1'b0; we_m = 1'b0; sel_m = '0; d_m = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(smp_out == '0, "R1 reset output", int'(smp_out), 0);
    check(mem_req == 1'b0, "R1 reset request", int'(mem_req), 0);
    check(blk_irq == 1'b0 && smp_tick == 1'b0, "R1 reset pulses", int'(blk_irq | smp_tick), 0);

    // sweep period (incl. clamp R9), volume (incl. saturation R8), length (incl. zero R10)
    foreach (pers[i]) foreach (vols[j]) foreach (lens[k]) begin
      cfg_write(SEL_PER, pers[i]);
      cfg_write(SEL_VOL, vols[j]);
      cfg_write(SEL_LEN, lens[k]);
      cfg_write(SEL_START, 16'h0040 + i * 32 + j * 8 + k);
      start_play();
      wait_ticks(10);
      stop_play();
    end

    // R7: start write on the same edge as the block-end reload
    cfg_write(SEL_PER, 5);
    cfg_write(SEL_VOL, 64);
    cfg_write(SEL_LEN, 2);
    cfg_write(SEL_START, 16'h0100);
    start_play();
    provoke_val = 16'h0200;
    provoke = 1;
    wait_ticks(16);
    check(provoke == 0, "R7 coincident write issued", int'(provoke), 0);
    // R7 plain queued write of length mid-block, then R5 looping on it
    cfg_write(SEL_LEN, 3);
    wait_ticks(16);
    stop_play();

    // R11 restart from latched start after a mid-block stop
    cfg_write(SEL_PER, 6);
    cfg_write(SEL_LEN, 4);
    cfg_write(SEL_START, 16'h0300);
    start_play();
    wait_ticks(5);
    stop_play();
    start_play();
    wait_ticks(6);
    stop_play();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule